// File: doc/BRIEF.md
# Prioritized Interrupt Sequencer

This block sits beside a small 8-bit processor core and decides when an interrupt is taken. It keeps a latched request flag and an enable bit for every source, as well as a global enable bit. When the global enable is set, an enabled source is pending and the core reports an instruction boundary, it accepts the most urgent source. It then clears the global enable and stalls the core for a fixed entry sequence. During that sequence it requests one push of the 9-bit program counter and finally presents the vector index of the chosen source. If the core is asleep, the request is accepted without a boundary strobe. In that case a 4-cycle wake-up period comes before the entry sequence.

A return command from the decoder starts a fixed 4-cycle return sequence. That sequence requests one program counter pop and sets the global enable again at its end. After a return, the first instruction boundary is never an acceptance point, so exactly one main-program instruction runs before the next interrupt. Sources are split into groups of eight, and each group has its own mask write strobe and its own write-one-to-clear flag strobe. Sources marked as level-type are never latched: they request service only while their input is held.

Top module: `irq_sequencer`

## Requirements
- R1: On acceptance, `gie` goes low in the next cycle and stays low through the whole entry sequence, and `core_stall` is high in every cycle of an entry, wake-up or return sequence.
- R2: An awake entry lasts exactly 4 stalled cycles. `pc_push` is high only in the first of them. `vec_valid` is high only in the fourth, with `vec_idx` equal to the source number plus 1 (index 0 is never issued).
- R3: While `sleeping` is high, an enabled pending source is accepted without `insn_done`. Four stalled wake-up cycles then come before the 4-cycle entry, so `pc_push` falls in stalled cycle 5 and `vec_valid` in stalled cycle 8.
- R4: While awake, an interrupt is accepted only in a cycle where `insn_done` is high. Without it, a pending enabled source never stalls the core.
- R5: A request on a latched source sets its bit in `flag_rd` even while its enable bit or `gie` is low. The bit stays set until the source is serviced or cleared by software. Reset clears all flags and enables and `gie`.
- R6: Issuing a vector clears that source's flag. Writing `flg_clr_wdata` with `flg_clr_we[g]` high clears flag bits `g*8+i` where data bit `i` is 1 and leaves other groups untouched. A new request in the same cycle as a clear leaves the flag set.
- R7: When several enabled sources are pending, the lowest source number is served first.
- R8: A `reti` pulse starts a return of exactly 4 stalled cycles. `pc_pop` is high only in the first of them, and `gie` reads 1 in the cycle after the last.
- R9: After a return, the first `insn_done` strobe does not start an entry, even with an enabled pending source and `gie` high. The next strobe can.
- R10: Level sources (bit set in `LEVEL_SRC`, default source 0) never show a flag in `flag_rd`. They are serviced only while their input is high, and a past pulse leaves nothing pending.
- R11: `msk_we[g]` writes `msk_wdata` bit `i` into the enable of source `g*8+i`. A disabled source is never served, even when a lower-numbered disabled source is pending.
- R12: `gie_we` loads `gie_wdata` into `gie` when no sequence is running. A write during a stalled sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 16 | Request per source (pulse for latched sources, level for level sources) |
| insn_done | input | 1 | Core instruction boundary strobe |
| sleeping | input | 1 | Core is in sleep mode |
| reti | input | 1 | Return-from-interrupt command |
| gie_we | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Global enable write value |
| msk_we | input | 2 | Enable mask write strobe per group |
| msk_wdata | input | 8 | Enable mask write data |
| flg_clr_we | input | 2 | Flag write-one-to-clear strobe per group |
| flg_clr_wdata | input | 8 | Flag clear data, a one clears that bit |
| flag_rd | output | 16 | Latched flag read-back |
| vec_valid | output | 1 | Vector index valid (last entry cycle) |
| vec_idx | output | 5 | Vector index, source number plus 1 |
| pc_push | output | 1 | Program counter push request |
| pc_pop | output | 1 | Program counter pop request |
| core_stall | output | 1 | Stall the core |
| gie | output | 1 | Current global enable |

## Verification
On every cycle, the embedded properties check several fixed relations. Each push is a single pulse, followed three cycles later by the vector, and the global enable stays low while the entry runs. A wake-up period ends in a push, and each pop leads to the global enable being set four cycles later. Vector issue clears the flag, a new request beats a clear, and the chosen source is the lowest-numbered active one. Some behaviours need a full scenario and are covered only by the bench's sequences. These are the exact stall counts, the vector numbering, the group split of the mask and clear writes, level sources never being latched, write attempts ignored during a stall, and the rule that the first boundary strobe after a return is not an acceptance point.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    // Fixed sequence length for wake-up, entry and return
    localparam int unsigned SEQ_CYC = 4;
    localparam int unsigned CNT_W   = $clog2(SEQ_CYC);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_ENTRY,
        ST_RET,
        ST_GRACE
    } seq_state_e;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int unsigned GRP_W = 8,
    parameter int unsigned GRP_N = 2,
    parameter logic [GRP_W*GRP_N-1:0] LEVEL_SRC = {{(GRP_W*GRP_N-1){1'b0}}, 1'b1}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [GRP_W*GRP_N-1:0]   req,
    input  logic [GRP_N-1:0]         msk_we,
    input  logic [GRP_W-1:0]         msk_wdata,
    input  logic [GRP_N-1:0]         clr_we,
    input  logic [GRP_W-1:0]         clr_wdata,
    input  logic [GRP_W*GRP_N-1:0]   hw_clr,
    output logic [GRP_W*GRP_N-1:0]   flags,
    output logic [GRP_W*GRP_N-1:0]   active
);

    localparam int unsigned SRC_N = GRP_W * GRP_N;

    typedef struct packed {
        logic [SRC_N-1:0] flag;
        logic [SRC_N-1:0] en;
    } bank_t;

    bank_t            b_d, b_q;
    logic [SRC_N-1:0] sw_clr;

    always_comb begin
        b_d    = b_q;
        sw_clr = '0;
        for (int g = 0; g < GRP_N; g++) begin
            if (msk_we[g]) b_d.en[g*GRP_W +: GRP_W] = msk_wdata;
            if (clr_we[g]) sw_clr[g*GRP_W +: GRP_W] = clr_wdata;
        end
        // a fresh request overrides any clear in the same cycle
        b_d.flag = ((b_q.flag & ~sw_clr & ~hw_clr) | req) & ~LEVEL_SRC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign flags  = b_q.flag;
    assign active = (b_q.flag | (req & LEVEL_SRC)) & b_q.en;

    // R6: a vector-issue clear removes the flag unless re-requested
    a_r6_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_clr & ~req)) |=> ((b_q.flag & $past(hw_clr & ~req)) == '0));

    // R6: a latched request always lands, whatever clear comes with it
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req & ~LEVEL_SRC)) |=>
        ((b_q.flag & $past(req & ~LEVEL_SRC)) == $past(req & ~LEVEL_SRC)));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned SRC_N = 16,
    parameter int unsigned VEC_W = $clog2(SRC_N + 1)
) (
    input  logic [SRC_N-1:0] active,
    output logic             any,
    output logic [VEC_W-1:0] vec
);

    always_comb begin
        any = |active;
        vec = '0;
        // scan downward so the lowest active source is the last to write
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (active[i]) vec = VEC_W'(i + 1);
        end
    end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int unsigned SRC_N = 16,
    parameter int unsigned VEC_W = $clog2(SRC_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick_any,
    input  logic [VEC_W-1:0] pick_vec,
    input  logic             insn_done,
    input  logic             sleeping,
    input  logic             reti,
    input  logic             gie_we,
    input  logic             gie_wdata,
    output logic             gie,
    output logic             stall,
    output logic             pc_push,
    output logic             pc_pop,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_idx,
    output logic [SRC_N-1:0] hw_clr
);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [VEC_W-1:0] vec;
        logic             gie;
    } fsm_t;

    fsm_t c_q, c_d;
    logic last;

    always_comb begin
        c_d  = c_q;
        last = (c_q.cnt == CNT_W'(SEQ_CYC - 1));
        unique case (c_q.st)
            ST_IDLE: begin
                if (reti) begin
                    c_d.st  = ST_RET;
                    c_d.cnt = '0;
                end else if (c_q.gie && pick_any && (insn_done || sleeping)) begin
                    c_d.vec = pick_vec;
                    c_d.gie = 1'b0;
                    c_d.cnt = '0;
                    c_d.st  = sleeping ? ST_WAKE : ST_ENTRY;
                end else if (gie_we) begin
                    c_d.gie = gie_wdata;
                end
            end
            ST_WAKE: begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (last) begin
                    c_d.st  = ST_ENTRY;
                    c_d.cnt = '0;
                end
            end
            ST_ENTRY: begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (last) begin
                    c_d.st  = ST_IDLE;
                    c_d.cnt = '0;
                end
            end
            ST_RET: begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (last) begin
                    c_d.st  = ST_GRACE;
                    c_d.cnt = '0;
                    c_d.gie = 1'b1;
                end
            end
            ST_GRACE: begin
                if (reti) begin
                    c_d.st  = ST_RET;
                    c_d.cnt = '0;
                end else begin
                    if (insn_done) c_d.st = ST_IDLE;
                    if (gie_we)    c_d.gie = gie_wdata;
                end
            end
            default: c_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, cnt: '0, vec: '0, gie: 1'b0};
        else        c_q <= c_d;
    end

    assign gie       = c_q.gie;
    assign stall     = (c_q.st == ST_WAKE) || (c_q.st == ST_ENTRY) || (c_q.st == ST_RET);
    assign pc_push   = (c_q.st == ST_ENTRY) && (c_q.cnt == '0);
    assign pc_pop    = (c_q.st == ST_RET) && (c_q.cnt == '0);
    assign vec_valid = (c_q.st == ST_ENTRY) && last;
    assign vec_idx   = vec_valid ? c_q.vec : '0;
    assign hw_clr    = vec_valid ? (SRC_N'(1) << (c_q.vec - VEC_W'(1))) : '0;

    // R1: global enable stays low while an entry or wake-up runs
    a_r1_gie_low_in_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_WAKE) || (c_q.st == ST_ENTRY)) |-> !c_q.gie);

    // R2: one push pulse, then the vector three cycles later
    a_r2_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        pc_push |=> !pc_push);
    a_r2_push_then_vec: assert property (@(posedge clk) disable iff (!rst_n)
        pc_push |-> ##3 vec_valid);

    // R3: the wake-up period hands over to the entry push
    a_r3_wake_to_push: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_WAKE) && last) |=> pc_push);

    // R8: a pop leads to the global enable four cycles later
    a_r8_pop_then_gie: assert property (@(posedge clk) disable iff (!rst_n)
        pc_pop |-> ##4 c_q.gie);

    // R9: no entry can start straight out of the post-return window
    a_r9_grace_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_GRACE) |=> !pc_push);

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
    parameter int unsigned GRP_W = 8,
    parameter int unsigned GRP_N = 2,
    parameter logic [GRP_W*GRP_N-1:0] LEVEL_SRC = {{(GRP_W*GRP_N-1){1'b0}}, 1'b1}
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [GRP_W*GRP_N-1:0]            irq_req,
    input  logic                              insn_done,
    input  logic                              sleeping,
    input  logic                              reti,
    input  logic                              gie_we,
    input  logic                              gie_wdata,
    input  logic [GRP_N-1:0]                  msk_we,
    input  logic [GRP_W-1:0]                  msk_wdata,
    input  logic [GRP_N-1:0]                  flg_clr_we,
    input  logic [GRP_W-1:0]                  flg_clr_wdata,
    output logic [GRP_W*GRP_N-1:0]            flag_rd,
    output logic                              vec_valid,
    output logic [$clog2(GRP_W*GRP_N+1)-1:0]  vec_idx,
    output logic                              pc_push,
    output logic                              pc_pop,
    output logic                              core_stall,
    output logic                              gie
);

    localparam int unsigned SRC_N = GRP_W * GRP_N;
    localparam int unsigned VEC_W = $clog2(SRC_N + 1);

    logic [SRC_N-1:0] src_active;
    logic [SRC_N-1:0] hw_clr;
    logic             pick_any;
    logic [VEC_W-1:0] pick_vec;

    irq_src_bank #(
        .GRP_W     (GRP_W),
        .GRP_N     (GRP_N),
        .LEVEL_SRC (LEVEL_SRC)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (irq_req),
        .msk_we    (msk_we),
        .msk_wdata (msk_wdata),
        .clr_we    (flg_clr_we),
        .clr_wdata (flg_clr_wdata),
        .hw_clr    (hw_clr),
        .flags     (flag_rd),
        .active    (src_active)
    );

    irq_prio_pick #(
        .SRC_N (SRC_N),
        .VEC_W (VEC_W)
    ) u_pick (
        .active (src_active),
        .any    (pick_any),
        .vec    (pick_vec)
    );

    irq_seq_fsm #(
        .SRC_N (SRC_N),
        .VEC_W (VEC_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pick_any  (pick_any),
        .pick_vec  (pick_vec),
        .insn_done (insn_done),
        .sleeping  (sleeping),
        .reti      (reti),
        .gie_we    (gie_we),
        .gie_wdata (gie_wdata),
        .gie       (gie),
        .stall     (core_stall),
        .pc_push   (pc_push),
        .pc_pop    (pc_pop),
        .vec_valid (vec_valid),
        .vec_idx   (vec_idx),
        .hw_clr    (hw_clr)
    );

    // R7: the picked source is active and no lower-numbered one is
    a_r7_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> ((pick_vec != '0)
                   && (((src_active >> (pick_vec - VEC_W'(1))) & SRC_N'(1)) == SRC_N'(1))
                   && ((src_active & ((SRC_N'(1) << (pick_vec - VEC_W'(1))) - SRC_N'(1))) == '0)));

endmodule

// File: tb/irq_sequencer_tb.sv
module irq_sequencer_tb;

    localparam int SN = 16;
    localparam int VW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [SN-1:0] irq_req;
    logic          insn_done, sleeping, reti, gie_we, gie_wdata;
    logic [1:0]    msk_we, flg_clr_we;
    logic [7:0]    msk_wdata, flg_clr_wdata;
    logic [SN-1:0] flag_rd;
    logic          vec_valid, pc_push, pc_pop, core_stall, gie;
    logic [VW-1:0] vec_idx;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    irq_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_done(insn_done),
        .sleeping(sleeping), .reti(reti), .gie_we(gie_we), .gie_wdata(gie_wdata),
        .msk_we(msk_we), .msk_wdata(msk_wdata), .flg_clr_we(flg_clr_we),
        .flg_clr_wdata(flg_clr_wdata), .flag_rd(flag_rd), .vec_valid(vec_valid),
        .vec_idx(vec_idx), .pc_push(pc_push), .pc_pop(pc_pop),
        .core_stall(core_stall), .gie(gie)
    );

    typedef struct packed {
        logic [SN-1:0] req;
        logic [SN-1:0] en;
        logic [VW-1:0] exp;
    } vec_t;

    // R7 priority table: expected vector is lowest enabled pending source + 1
    localparam vec_t TBL [6] = '{
        '{16'h0002, 16'h0002, 5'd2},
        '{16'h0006, 16'h0006, 5'd2},
        '{16'h0006, 16'h0004, 5'd3},
        '{16'h8100, 16'hFF00, 5'd9},
        '{16'h8000, 16'h8000, 5'd16},
        '{16'h0010, 16'h0000, 5'd0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_gie(input logic v);
        gie_we = 1'b1; gie_wdata = v; step(); gie_we = 1'b0;
    endtask

    task automatic wr_msk(input logic [SN-1:0] en);
        msk_we = 2'b01; msk_wdata = en[7:0];  step();
        msk_we = 2'b10; msk_wdata = en[15:8]; step();
        msk_we = 2'b00;
    endtask

    task automatic clr_all();
        flg_clr_we = 2'b11; flg_clr_wdata = 8'hFF; step(); flg_clr_we = 2'b00;
    endtask

    task automatic pulse_req(input logic [SN-1:0] v);
        irq_req = v; step(); irq_req = '0;
    endtask

    task automatic strobe();
        insn_done = 1'b1; step(); insn_done = 1'b0;
    endtask

    task automatic run_entry(input int exp, input bit slept, input string tag);
        int n = 0;
        int push_at = -1;
        int pushes = 0;
        bit stall_ok = 1'b1;
        if (slept) sleeping = 1'b1; else insn_done = 1'b1;
        step();
        insn_done = 1'b0; sleeping = 1'b0;
        while (!vec_valid && n < 20) begin
            if (pc_push) begin push_at = n; pushes++; end
            if (!core_stall || gie) stall_ok = 1'b0;
            n++;
            step();
        end
        chk(n == (slept ? 7 : 3), {tag, " R2 vec cycle"}, n, slept ? 7 : 3);
        chk(push_at == (slept ? 4 : 0) && pushes == 1, {tag, " R3 push cycle"}, push_at, slept ? 4 : 0);
        chk(stall_ok && core_stall && !gie, {tag, " R1 stall and gie"}, stall_ok, 1);
        chk(vec_idx == VW'(exp), {tag, " R7 vector"}, vec_idx, exp);
        step();
        chk(!core_stall && !vec_valid, {tag, " R2 entry end"}, core_stall, 0);
    endtask

    task automatic run_return(input string tag);
        int n = 0;
        int pops = 0;
        reti = 1'b1; step(); reti = 1'b0;
        while (core_stall && n < 20) begin
            if (pc_pop) pops++;
            n++;
            step();
        end
        chk(n == 4, {tag, " R8 return length"}, n, 4);
        chk(pops == 1, {tag, " R8 single pop"}, pops, 1);
        chk(gie == 1'b1, {tag, " R8 gie set"}, gie, 1);
    endtask

    task automatic finish_service();
        wr_gie(1'b0);
        strobe();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; insn_done = 0; sleeping = 0; reti = 0;
        gie_we = 0; gie_wdata = 0; msk_we = '0; msk_wdata = '0;
        flg_clr_we = '0; flg_clr_wdata = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // reset state
        chk(!core_stall && !pc_push && !pc_pop, "R1 reset stall", core_stall, 0);
        chk(!vec_valid && vec_idx == '0, "R2 reset vector", vec_idx, 0);
        chk(flag_rd == '0, "R5 reset flags", flag_rd, 0);
        chk(gie == 1'b0, "R12 reset gie", gie, 0);

        // table walk: priority and masking
        for (int k = 0; k < 6; k++) begin
            clr_all();
            wr_msk(TBL[k].en);
            pulse_req(TBL[k].req);
            chk(flag_rd == TBL[k].req, "R5 flags latched while masked", flag_rd, TBL[k].req);
            wr_gie(1'b1);
            if (TBL[k].exp != 0) begin
                run_entry(TBL[k].exp, 1'b0, "R7 table");
                chk((flag_rd & (SN'(1) << (TBL[k].exp - 1))) == '0, "R6 served flag cleared",
                    flag_rd, 0);
                run_return("R8 table");
                finish_service();
            end else begin
                strobe();
                step();
                chk(!core_stall, "R11 disabled source ignored", core_stall, 0);
                chk(flag_rd == TBL[k].req, "R5 flag held while disabled", flag_rd, TBL[k].req);
                wr_gie(1'b0);
            end
        end

        // R4: no boundary strobe, no entry; R12: gie write during stall ignored
        clr_all();
        wr_msk(16'h0010);
        pulse_req(16'h0010);
        wr_gie(1'b1);
        repeat (5) step();
        chk(!core_stall, "R4 waits for boundary", core_stall, 0);
        strobe();
        gie_we = 1'b1; gie_wdata = 1'b1; step(); gie_we = 1'b0;
        chk(core_stall && gie == 1'b0, "R12 write during stall ignored", gie, 0);
        for (int w = 0; w < 10 && core_stall; w++) step();
        run_return("R8 after R4");
        finish_service();

        // R3: acceptance from sleep
        clr_all();
        wr_msk(16'h0020);
        pulse_req(16'h0020);
        wr_gie(1'b1);
        run_entry(6, 1'b1, "R3 sleep");
        run_return("R8 after sleep");
        finish_service();

        // R9: first strobe after return is not an acceptance point
        clr_all();
        wr_msk(16'h0060);
        pulse_req(16'h0060);
        wr_gie(1'b1);
        run_entry(6, 1'b0, "R9 first");
        run_return("R9 return");
        strobe();
        chk(!core_stall && !pc_push, "R9 first strobe blocked", core_stall, 0);
        step();
        chk(!core_stall, "R9 stays idle", core_stall, 0);
        run_entry(7, 1'b0, "R9 second");
        run_return("R9 second return");
        finish_service();

        // R10: level source
        clr_all();
        wr_msk(16'h0001);
        pulse_req(16'h0001);
        chk(flag_rd == '0, "R10 level never latched", flag_rd, 0);
        wr_gie(1'b1);
        strobe();
        step();
        chk(!core_stall, "R10 released level not pending", core_stall, 0);
        irq_req = 16'h0001;
        step();
        chk(flag_rd == '0, "R10 held level no flag", flag_rd, 0);
        run_entry(1, 1'b0, "R10 level");
        irq_req = '0;
        run_return("R10 return");
        finish_service();

        // R6: set beats clear, group-selective clear
        clr_all();
        wr_msk('0);
        irq_req = 16'h0008; flg_clr_we = 2'b01; flg_clr_wdata = 8'h08; step();
        irq_req = '0; flg_clr_we = 2'b00;
        chk(flag_rd == 16'h0008, "R6 set wins over clear", flag_rd, 16'h0008);
        flg_clr_we = 2'b10; flg_clr_wdata = 8'h08; step(); flg_clr_we = 2'b00;
        chk(flag_rd == 16'h0008, "R6 other group untouched", flag_rd, 16'h0008);
        flg_clr_we = 2'b01; flg_clr_wdata = 8'h08; step(); flg_clr_we = 2'b00;
        chk(flag_rd == '0, "R6 write one clears", flag_rd, 0);

        // R11: group mask write enables only the upper group
        pulse_req(16'h0102);
        msk_we = 2'b10; msk_wdata = 8'h01; step(); msk_we = 2'b00;
        wr_gie(1'b1);
        run_entry(9, 1'b0, "R11 group mask");
        chk(flag_rd == 16'h0002, "R11 lower disabled flag kept", flag_rd, 16'h0002);
        run_return("R11 return");
        finish_service();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule